// File: doc/BRIEF.md
# Memory-Reference Operand Sequencer

This block runs the memory-reference stage of a 24-bit processor. When it is started with an instruction word, it works out the addressing mode and forms a 16-bit effective address. For an argument-reading opcode it then returns a 24-bit argument. That argument is either taken from memory or built from the instruction's own immediate field. For a store opcode it writes a whole word, or a part of one, into a synchronous single-port memory. Memory read data arrives on the clock after the read request.

Every state of the sequencer lasts one clock. An immediate argument is ready after one clock. Direct and indirect memory arguments take two and three clocks. Stores take two clocks when direct and three when indirect. Indirection goes one level only: the low 16 bits of the pointer word are the final address, whatever its other bits hold.

A store does not read the target word first. It drives a two-bit field enable so that the memory itself keeps the bits that are not selected. The ALU, program counter handling and I/O belong to the surrounding core.

Top module: `opnd_seq`

## Requirements
- R1: Instruction vector bits [23:18] are the opcode, [17] the immediate flag, [16] the indirect flag and [15:0] the address field. ea_o shows the address field for direct operations.
- R2: Consider a non-store opcode with the immediate flag set, whatever the indirect flag holds. Its argument is instr[16:0] sign-extended to 24 bits, with instr[16] as the sign. done_o rises one clock after start is taken, and there is no memory request.
- R3: A non-store opcode with both flags clear reads memory at the address field. The returned word is presented as the argument, and done_o rises two clocks after start is taken.
- R4: With the indirect flag set and immediate mode not selected, the word at the address field is read as a pointer. Its bits [15:0] become the effective address, and its bits [23:16] are ignored. A read operation then fetches the argument there, finishing after three clocks. A store writes there, finishing after three clocks.
- R5: Opcode octal 20 writes acc_i with mem_be_o = 2'b11. A direct store finishes in two clocks, and the write is issued in the clock before done_o.
- R6: Opcode octal 21 writes acc_i with mem_be_o = 2'b01, so only vector bits [15:0] of the target change.
- R7: Opcode octal 22 writes acc_i with mem_be_o = 2'b10, so only vector bits [23:16] of the target change.
- R8: Opcode octal 23 writes mq_i as a whole word. Opcode octal 24 writes an all-zero whole word.
- R9: For store opcodes the immediate flag has no effect. Addressing follows the indirect flag alone.
- R10: done_o is high for exactly one clock per operation. arg_valid_o is high only together with done_o, and only for non-store opcodes. A read and a write are never requested in the same clock.
- R11: While an operation is in progress, start_i and changes on instr_i are ignored. Only one operation runs per accepted start.
- R12: During reset and right after it, done_o, arg_valid_o, mem_rd_o and mem_wr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an operation with instr_i (taken only when idle) |
| instr_i | input | 24 | Instruction word |
| acc_i | input | 24 | Accumulator value, used in the store clock |
| mq_i | input | 24 | MQ register value, used in the store clock |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 24 | Memory write data |
| mem_be_o | output | 2 | Field enable: bit 1 = vector [23:16], bit 0 = vector [15:0] |
| mem_rdata_i | input | 24 | Memory read data, one clock after the read request |
| arg_o | output | 24 | Argument for read operations |
| arg_valid_o | output | 1 | arg_o is valid (with done_o) |
| ea_o | output | 16 | Effective address of the finished operation |
| done_o | output | 1 | One-clock completion pulse |

## Verification
Some properties are checked by the assertions on every clock:
- done_o lasts one clock, and arg_valid_o never appears without it.
- Reads and writes never overlap.
- Every write is followed by done_o, and a write always carries a non-empty field enable.
- The indirect state is never held for two clocks.
- The address state is entered only from idle.

Only the bench scenarios can show the data and timing values:
- the sign extension of immediates;
- the exact completion clock for each mode;
- which bits a partial store preserves;
- the pointer-masking of indirection;
- the choice of store source.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

  localparam int OPW = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_IND,
    ST_FETCH,
    ST_STORE,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_ACC,
    SRC_MQ,
    SRC_ZERO
  } wsrc_e;

  // store opcodes (octal)
  localparam logic [OPW-1:0] OPC_PUT_WORD = 6'o20;
  localparam logic [OPW-1:0] OPC_PUT_LO   = 6'o21;
  localparam logic [OPW-1:0] OPC_PUT_HI   = 6'o22;
  localparam logic [OPW-1:0] OPC_PUT_MQ   = 6'o23;
  localparam logic [OPW-1:0] OPC_PUT_ZERO = 6'o24;

  typedef struct packed {
    logic       is_store;
    logic       imm;
    logic       ind;
    wsrc_e      src;
    logic [1:0] lanes;
  } dec_s;

endpackage

// File: rtl/opnd_decode.sv
module opnd_decode
  import opnd_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 16
) (
  input  logic [DW-1:0] instr_i,
  output dec_s          dec_o,
  output logic [AW-1:0] addr_fld_o,
  output logic [DW-1:0] imm_val_o
);

  localparam int OP_LSB  = DW - OPW;
  localparam int IMM_POS = OP_LSB - 1;
  localparam int IND_POS = AW;
  localparam int EXT_W   = DW - AW - 1;

  logic [OPW-1:0] opc;

  assign opc        = instr_i[DW-1:OP_LSB];
  assign addr_fld_o = instr_i[AW-1:0];
  // indirect flag doubles as the sign of the immediate
  assign imm_val_o  = {{EXT_W{instr_i[IND_POS]}}, instr_i[IND_POS:0]};

  always_comb begin
    dec_o          = '0;
    dec_o.imm      = instr_i[IMM_POS];
    dec_o.ind      = instr_i[IND_POS];
    dec_o.src      = SRC_ACC;
    dec_o.lanes    = 2'b00;
    case (opc)
      OPC_PUT_WORD: begin dec_o.is_store = 1'b1; dec_o.lanes = 2'b11; end
      OPC_PUT_LO:   begin dec_o.is_store = 1'b1; dec_o.lanes = 2'b01; end
      OPC_PUT_HI:   begin dec_o.is_store = 1'b1; dec_o.lanes = 2'b10; end
      OPC_PUT_MQ:   begin dec_o.is_store = 1'b1; dec_o.lanes = 2'b11; dec_o.src = SRC_MQ; end
      OPC_PUT_ZERO: begin dec_o.is_store = 1'b1; dec_o.lanes = 2'b11; dec_o.src = SRC_ZERO; end
      default:      ;
    endcase
  end

endmodule

// File: rtl/opnd_wbuild.sv
module opnd_wbuild
  import opnd_pkg::*;
#(
  parameter int DW = 24
) (
  input  wsrc_e         src_i,
  input  logic [1:0]    lanes_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mq_i,
  output logic [DW-1:0] wdata_o,
  output logic [1:0]    be_o
);

  always_comb begin
    case (src_i)
      SRC_MQ:   wdata_o = mq_i;
      SRC_ZERO: wdata_o = '0;
      default:  wdata_o = acc_i;
    endcase
  end

  assign be_o = lanes_i;

endmodule

// File: rtl/opnd_fsm.sv
module opnd_fsm
  import opnd_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] instr_i,
  input  logic          is_store_i,
  input  logic          imm_i,
  input  logic          ind_i,
  input  logic [AW-1:0] addr_fld_i,
  input  logic [DW-1:0] imm_val_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] ir_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] arg_o,
  output logic [AW-1:0] ea_o,
  output logic          done_o,
  output logic          arg_valid_o
);

  seq_state_e    st_q, st_d;
  logic [DW-1:0] ir_q;
  logic [AW-1:0] ea_q, ea_d;
  logic [DW-1:0] arg_q, arg_d;
  logic          ir_en, ea_en, arg_en;
  logic          use_imm;

  assign use_imm = imm_i && !is_store_i;  // stores ignore the immediate flag

  always_comb begin
    st_d       = st_q;
    ea_d       = ea_q;
    arg_d      = arg_q;
    ir_en      = 1'b0;
    ea_en      = 1'b0;
    arg_en     = 1'b0;
    mem_rd_o   = 1'b0;
    mem_wr_o   = 1'b0;
    mem_addr_o = ea_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          ir_en = 1'b1;
          st_d  = ST_ADDR;
        end
      end
      ST_ADDR: begin
        ea_en = 1'b1;
        ea_d  = addr_fld_i;
        if (use_imm) begin
          arg_en = 1'b1;
          arg_d  = imm_val_i;
          st_d   = ST_DONE;
        end else if (ind_i) begin
          mem_rd_o   = 1'b1;
          mem_addr_o = addr_fld_i;
          st_d       = ST_IND;
        end else if (is_store_i) begin
          st_d = ST_STORE;
        end else begin
          mem_rd_o   = 1'b1;
          mem_addr_o = addr_fld_i;
          st_d       = ST_FETCH;
        end
      end
      ST_IND: begin
        // one level only: pointer low bits are final
        ea_en = 1'b1;
        ea_d  = mem_rdata_i[AW-1:0];
        if (is_store_i) begin
          st_d = ST_STORE;
        end else begin
          mem_rd_o   = 1'b1;
          mem_addr_o = mem_rdata_i[AW-1:0];
          st_d       = ST_FETCH;
        end
      end
      ST_FETCH: begin
        arg_en = 1'b1;
        arg_d  = mem_rdata_i;
        st_d   = ST_DONE;
      end
      ST_STORE: begin
        mem_wr_o = 1'b1;
        st_d     = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ir_q  <= '0;
      ea_q  <= '0;
      arg_q <= '0;
    end else begin
      st_q <= st_d;
      if (ir_en)  ir_q  <= instr_i;
      if (ea_en)  ea_q  <= ea_d;
      if (arg_en) arg_q <= arg_d;
    end
  end

  assign ir_o        = ir_q;
  assign arg_o       = arg_q;
  assign ea_o        = ea_q;
  assign done_o      = (st_q == ST_DONE);
  assign arg_valid_o = done_o && !is_store_i;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R10
  AST_VALID_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    arg_valid_o |-> done_o);  // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));  // R10
  AST_WR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> done_o);  // R5
  AST_IND_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IND) |=> (st_q != ST_IND));  // R4
  AST_ADDR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR) |-> ($past(st_q) == ST_IDLE));  // R11

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
  import opnd_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] instr_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mq_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [1:0]    mem_be_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] arg_o,
  output logic          arg_valid_o,
  output logic [AW-1:0] ea_o,
  output logic          done_o
);

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic [DW-1:0] ir;
  dec_s          dec;
  logic [AW-1:0] addr_fld;
  logic [DW-1:0] imm_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  opnd_decode #(.DW(DW), .AW(AW)) u_decode (
    .instr_i    (ir),
    .dec_o      (dec),
    .addr_fld_o (addr_fld),
    .imm_val_o  (imm_val)
  );

  opnd_fsm #(.DW(DW), .AW(AW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .instr_i     (instr_i),
    .is_store_i  (dec.is_store),
    .imm_i       (dec.imm),
    .ind_i       (dec.ind),
    .addr_fld_i  (addr_fld),
    .imm_val_i   (imm_val),
    .mem_rdata_i (mem_rdata_i),
    .ir_o        (ir),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o),
    .arg_o       (arg_o),
    .ea_o        (ea_o),
    .done_o      (done_o),
    .arg_valid_o (arg_valid_o)
  );

  opnd_wbuild #(.DW(DW)) u_wbuild (
    .src_i   (dec.src),
    .lanes_i (dec.lanes),
    .acc_i   (acc_i),
    .mq_i    (mq_i),
    .wdata_o (mem_wdata_o),
    .be_o    (mem_be_o)
  );

  AST_WR_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_o |-> (mem_be_o != 2'b00));  // R6
  AST_WR_NO_ARG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_o |=> !arg_valid_o);  // R10

endmodule

// File: tb/opnd_seq_tb.sv
module opnd_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [23:0] instr_i, acc_i, mq_i;
  logic        mem_rd_o, mem_wr_o;
  logic [15:0] mem_addr_o;
  logic [23:0] mem_wdata_o;
  logic [1:0]  mem_be_o;
  logic [23:0] mem_rdata_i;
  logic [23:0] arg_o;
  logic        arg_valid_o;
  logic [15:0] ea_o;
  logic        done_o;

  int total = 0;
  int bad   = 0;

  logic [23:0] mem     [logic [15:0]];
  logic [23:0] exp_mem [logic [15:0]];
  logic [23:0] old_w;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  opnd_seq u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .instr_i (instr_i),
    .acc_i (acc_i), .mq_i (mq_i), .mem_rd_o (mem_rd_o), .mem_wr_o (mem_wr_o),
    .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o), .mem_be_o (mem_be_o),
    .mem_rdata_i (mem_rdata_i), .arg_o (arg_o), .arg_valid_o (arg_valid_o),
    .ea_o (ea_o), .done_o (done_o)
  );

  // synchronous memory with two field enables
  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= mem.exists(mem_addr_o) ? mem[mem_addr_o] : 24'h0;
    if (mem_wr_o) begin
      old_w = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 24'h0;
      mem[mem_addr_o] = {mem_be_o[1] ? mem_wdata_o[23:16] : old_w[23:16],
                         mem_be_o[0] ? mem_wdata_o[15:0]  : old_w[15:0]};
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] xrd(input logic [15:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 24'h0;
  endfunction

  function automatic logic [23:0] mk(input logic [5:0] op, input bit imm, input bit ind, input logic [15:0] a);
    return {op, imm, ind, a};
  endfunction

  task automatic preload(input logic [15:0] a, input logic [23:0] d);
    mem[a] = d;
    exp_mem[a] = d;
  endtask

  // behavioural reference: derive timing and values from the requirements
  task automatic run_op(input logic [23:0] ins, input logic [23:0] acc, input logic [23:0] mq,
                        input bit hold, input string tag);
    logic [5:0]  op;
    bit          st, imm, ind;
    int          n;
    logic [15:0] ea;
    logic [23:0] exp_arg, src, newv, oldv;
    logic [1:0]  be;
    op  = ins[23:18];
    imm = ins[17];
    ind = ins[16];
    st  = (op >= 6'o20) && (op <= 6'o24);
    n   = (!st && imm) ? 1 : (ind ? 3 : 2);
    ea  = ind && !(imm && !st) ? xrd(ins[15:0])[15:0] : ins[15:0];
    exp_arg = (!st && imm) ? {{7{ins[16]}}, ins[16:0]} : xrd(ea);
    be  = (op == 6'o21) ? 2'b01 : (op == 6'o22) ? 2'b10 : 2'b11;
    src = (op == 6'o23) ? mq : (op == 6'o24) ? 24'h0 : acc;
    oldv = xrd(ea);
    newv = {be[1] ? src[23:16] : oldv[23:16], be[0] ? src[15:0] : oldv[15:0]};

    @(negedge clk);
    start_i = 1'b1; instr_i = ins; acc_i = acc; mq_i = mq;
    @(posedge clk);
    @(negedge clk);
    if (!hold) start_i = 1'b0;
    instr_i = ~ins;  // must be ignored once taken (R11)
    if (!st && imm) chk(mem_rd_o === 1'b0, {tag, " R2 no memory read"}, {23'h0, mem_rd_o}, 24'h0);
    for (int k = 1; k <= n + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(done_o === (k == n), {tag, " R10 done timing"}, {23'h0, done_o}, {23'h0, k == n});
      if (st) begin
        chk(mem_wr_o === (k == n - 1), {tag, " R5 write clock"}, {23'h0, mem_wr_o}, {23'h0, k == n - 1});
        if (k == n - 1) begin
          chk(mem_addr_o === ea, {tag, " R4 write address"}, {8'h0, mem_addr_o}, {8'h0, ea});
          chk(mem_be_o === be, {tag, " R6 R7 field enable"}, {22'h0, mem_be_o}, {22'h0, be});
        end
      end else begin
        chk(mem_wr_o === 1'b0, {tag, " R10 no write on read op"}, {23'h0, mem_wr_o}, 24'h0);
      end
      if (k == n) begin
        chk(arg_valid_o === !st, {tag, " R10 arg_valid"}, {23'h0, arg_valid_o}, {23'h0, !st});
        if (!st) chk(arg_o === exp_arg, {tag, " R2 R3 R4 argument"}, arg_o, exp_arg);
        chk(ea_o === ea, {tag, " R1 effective address"}, {8'h0, ea_o}, {8'h0, ea});
        if (hold) start_i = 1'b0;
      end
    end
    if (hold) begin
      @(posedge clk);
      @(negedge clk);
      chk(done_o === 1'b0 && mem_rd_o === 1'b0, {tag, " R11 no second run"},
          {22'h0, done_o, mem_rd_o}, 24'h0);
    end
    if (st) begin
      exp_mem[ea] = newv;
      chk(mem.exists(ea) && mem[ea] === newv, {tag, " R5 R6 R7 R8 stored word"},
          mem.exists(ea) ? mem[ea] : 24'hx, newv);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; instr_i = '0; acc_i = '0; mq_i = '0;
    preload(16'h0010, 24'h123456);
    preload(16'hFFFE, 24'h00F00D);
    preload(16'h0020, 24'hFF0030);   // pointer with upper bits and its own bit 16 set
    preload(16'h0030, 24'hABCDEF);
    preload(16'h0100, 24'hA5A5A5);
    preload(16'h0101, 24'h5A5A5A);
    preload(16'h0040, 24'h000102);
    preload(16'h0102, 24'h777777);
    preload(16'h0103, 24'h111111);
    preload(16'h0104, 24'h222222);
    repeat (3) @(negedge clk);
    chk(done_o === 1'b0 && arg_valid_o === 1'b0 && mem_rd_o === 1'b0 && mem_wr_o === 1'b0,
        "R12 outputs in reset", {20'h0, done_o, arg_valid_o, mem_rd_o, mem_wr_o}, 24'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o === 1'b0 && mem_rd_o === 1'b0 && mem_wr_o === 1'b0,
        "R12 outputs after reset", {21'h0, done_o, mem_rd_o, mem_wr_o}, 24'h0);

    run_op(mk(6'o03, 1'b1, 1'b0, 16'h1234), 24'h0, 24'h0, 1'b0, "imm_pos R2");
    run_op(mk(6'o10, 1'b1, 1'b1, 16'h0005), 24'h0, 24'h0, 1'b0, "imm_neg R2");
    run_op(mk(6'o03, 1'b0, 1'b0, 16'h0010), 24'h0, 24'h0, 1'b0, "direct R3");
    run_op(mk(6'o05, 1'b0, 1'b0, 16'hFFFE), 24'h0, 24'h0, 1'b0, "direct_top R1");
    run_op(mk(6'o04, 1'b0, 1'b1, 16'h0020), 24'h0, 24'h0, 1'b0, "indirect R4");
    run_op(mk(6'o20, 1'b0, 1'b0, 16'h0100), 24'h0BEEF1, 24'h0, 1'b0, "put_word R5");
    run_op(mk(6'o21, 1'b0, 1'b0, 16'h0101), 24'h123456, 24'h0, 1'b0, "put_lo R6");
    run_op(mk(6'o22, 1'b0, 1'b1, 16'h0040), 24'hC0FFEE, 24'h0, 1'b0, "put_hi_ind R7");
    run_op(mk(6'o23, 1'b0, 1'b0, 16'h0103), 24'h999999, 24'h246801, 1'b0, "put_mq R8");
    run_op(mk(6'o24, 1'b0, 1'b0, 16'h0100), 24'hFFFFFF, 24'hFFFFFF, 1'b0, "put_zero R8");
    run_op(mk(6'o20, 1'b1, 1'b0, 16'h0104), 24'h3C3C3C, 24'h0, 1'b0, "store_imm R9");
    run_op(mk(6'o03, 1'b0, 1'b0, 16'h0010), 24'h0, 24'h0, 1'b1, "busy_start R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule